// File: doc/BRIEF.md
# Framed Serial Configuration Receiver

This block accepts write-only configuration words over a three-wire link (an active-low select, a serial clock and a data line) and holds them in four control registers whose fields drive the rest of an imaging front end as parallel levels. Each transfer is a sixteen-bit frame sent least significant bit first. The data line is sampled on every rising serial-clock edge while select is low. The frame is acted on only when select returns high, and only if exactly sixteen edges arrived.

The two lowest bits of a committed word choose the destination register, and the remaining fourteen bits replace that register's contents. The other three registers keep their values. The serial pins are asynchronous to the system clock: the block brings them in through two-flop synchronisers and detects their edges in the fast system clock domain. A frame with too few or too many edges, or one abandoned part way, changes nothing.

Fields: an eleven-bit two's-complement gain code, a five-bit clamp code, a four-bit offset code with its enable, calibration and core-run controls, a low-rate clock selection, two strobe polarity bits, a sleep request and four output-mode bits. A clamp code above 24 is stored as sent but also raises a sticky error flag.

Top module: `ctrl_frame_rx`

## Requirements
- R1: After a synchronous active-low reset, every field output and `clamp_err` read zero.
- R2: Data is sampled on each rising `ser_clk` edge while `ser_sel_n` is low. The first bit received becomes word bit 0 and the sixteenth becomes bit 15.
- R3: A frame with fewer than sixteen rising edges leaves every register unchanged.
- R4: A frame with more than sixteen rising edges leaves every register unchanged. The internal edge counter saturates at seventeen.
- R5: A complete frame takes effect only after `ser_sel_n` rises. While select stays low, the outputs hold their previous values.
- R6: Word bits 1:0 select the register (0 gain, 1 black level, 2 control, 3 output mode). Bits 15:2 become that register's payload, and the other registers are untouched.
- R7: Register 0: `gain_code` is word bits 12:2, taken as an 11-bit two's-complement value (+1023 to -81 are the meaningful codes).
- R8: Register 1: `clamp_code` is bits 6:2, `ofs_code` is bits 10:7 and `ofs_use` is bit 11.
- R9: Register 2: `calib_run` is bit 2, `core_run` bit 3, `slow_clk` bit 4, `strobe_inv` bit 5, `black_inv` bit 6 and `sleep_req` bit 7.
- R10: Register 3: `test_mode` is bit 2, `msb_inv` bit 3, `all_inv` bit 4 and `standby` bit 5.
- R11: Committing a clamp code above 24 stores it and sets `clamp_err`. The flag then stays set until reset, even after later valid codes.
- R12: Rising `ser_clk` edges while `ser_sel_n` is high shift nothing and do not count towards the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel_n | input | 1 | Frame select, low during a transfer |
| ser_clk | input | 1 | Serial clock, data sampled on rising edge |
| ser_data | input | 1 | Serial data, LSB first |
| gain_code | output | 11 | Two's-complement gain code |
| clamp_code | output | 5 | Black clamp level code |
| clamp_err | output | 1 | Sticky flag: clamp code above 24 was committed |
| ofs_code | output | 4 | Sensor offset correction code |
| ofs_use | output | 1 | Offset correction enable |
| calib_run | output | 1 | Offset calibration mode request |
| core_run | output | 1 | Core out of reset when high |
| slow_clk | output | 1 | Low conversion-rate selection |
| strobe_inv | output | 1 | Sampling strobe polarity inversion |
| black_inv | output | 1 | Optical-black pulse polarity inversion |
| sleep_req | output | 1 | Sleep request |
| test_mode | output | 1 | Output test pattern mode |
| msb_inv | output | 1 | Output MSB inversion |
| all_inv | output | 1 | Output full-word inversion |
| standby | output | 1 | Output standby |

## Verification
The bench builds the block with its default sixteen-bit word and two synchroniser stages. The commit count and the saturation at seventeen edges therefore fall on frames short enough to send many times, including one-bit, fifteen-bit and seventeen-bit frames. The serial clock runs at twelve system clocks per period, so every synchronised edge is seen. The bench also covers a frame held open past its sixteenth edge, stray clocks while deselected, and a mid-run reset.

// File: rtl/ctrl_rx_pkg.sv
// Shared constants for the framed serial configuration receiver.
// Field positions are given as offsets into a register payload (word bits above the address).
package ctrl_rx_pkg;
    localparam int ADDR_W    = 2;
    localparam int NUM_REGS  = 2 ** ADDR_W;
    localparam int GAIN_W    = 11;
    localparam int CLAMP_W   = 5;
    localparam int OFS_W     = 4;
    localparam int CLAMP_MAX = 24;

    // payload offsets, register 1
    localparam int P_CLAMP   = 0;
    localparam int P_OFS     = P_CLAMP + CLAMP_W;
    localparam int P_OFS_USE = P_OFS + OFS_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_GAIN    = 2'd0,
        REG_BLACK   = 2'd1,
        REG_CTRL    = 2'd2,
        REG_OUTMODE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ctrl_rx_sync.sv
// Multi-bit flop synchroniser for slow asynchronous pins.
// Assumes each bit is independent and changes far slower than clk.
module ctrl_rx_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pins through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ctrl_rx_shift.sv
// Frame shifter: detects serial clock and select edges from synchronised levels,
// shifts data LSB first and counts edges with saturation at WORD_W+1.
// Asserts commit for one cycle when select rises after exactly WORD_W edges.
module ctrl_rx_shift #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              commit,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic sel_q, sclk_q;
    logic sel_rise, sclk_rise;

    // Remember previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            sel_q  <= sel_n_s;
            sclk_q <= sclk_s;
        end
    end

    assign sel_rise  = sel_n_s & ~sel_q;
    assign sclk_rise = sclk_s & ~sclk_q;

    // Shift register and saturating edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (sel_rise) begin
            cnt <= '0;
        end else if (!sel_n_s && sclk_rise) begin
            word <= {sdat_s, word[WORD_W-1:1]};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

    assign commit = sel_rise && (cnt == CNT_FULL);
endmodule

// File: rtl/ctrl_rx_bank.sv
// Register bank: on commit, the register addressed by the low word bits takes the payload.
// Assumes commit is a single-cycle pulse with word stable in that cycle.
module ctrl_rx_bank #(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 2,
    parameter int NUM_REGS = 2 ** ADDR_W,
    parameter int PAY_W    = WORD_W - ADDR_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [WORD_W-1:0]                 word,
    output logic [NUM_REGS-1:0][PAY_W-1:0]    reg_q
);
    logic [ADDR_W-1:0] addr;
    assign addr = word[ADDR_W-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Load register i when a committed frame addresses it
        always_ff @(posedge clk) begin
            if (!rst_n)                                 reg_q[i] <= '0;
            else if (commit && addr == ADDR_W'(i))      reg_q[i] <= word[WORD_W-1:ADDR_W];
        end
    end
endmodule

// File: rtl/ctrl_frame_rx.sv
// Framed serial configuration receiver top.
// Assumes the serial pins are asynchronous and at least several clk periods per level.
// Outputs are register slices; clamp_err is sticky until reset.
module ctrl_frame_rx
    import ctrl_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_sel_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [CLAMP_W-1:0] clamp_code,
    output logic               clamp_err,
    output logic [OFS_W-1:0]   ofs_code,
    output logic               ofs_use,
    output logic               calib_run,
    output logic               core_run,
    output logic               slow_clk,
    output logic               strobe_inv,
    output logic               black_inv,
    output logic               sleep_req,
    output logic               test_mode,
    output logic               msb_inv,
    output logic               all_inv,
    output logic               standby
);
    localparam int PAY_W = WORD_W - ADDR_W;
    localparam int CNT_W = $clog2(WORD_W + 2);

    logic [2:0]                          pins_s;
    logic                                commit;
    logic [WORD_W-1:0]                   frame_word;
    logic [CNT_W-1:0]                    frame_cnt;
    logic [NUM_REGS-1:0][PAY_W-1:0]      reg_q;
    logic                                clamp_bad;

    ctrl_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ser_sel_n, ser_clk, ser_data}),
        .dout(pins_s)
    );

    ctrl_rx_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdat_s(pins_s[0]),
        .commit(commit), .word(frame_word), .cnt(frame_cnt)
    );

    ctrl_rx_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PAY_W(PAY_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .word(frame_word),
        .reg_q(reg_q)
    );

    assign clamp_bad = commit && (frame_word[ADDR_W-1:0] == REG_BLACK)
                       && (frame_word[ADDR_W+P_CLAMP +: CLAMP_W] > CLAMP_W'(CLAMP_MAX));

    // Sticky flag for out-of-range clamp codes
    always_ff @(posedge clk) begin
        if (!rst_n)         clamp_err <= 1'b0;
        else if (clamp_bad) clamp_err <= 1'b1;
    end

    assign gain_code  = reg_q[REG_GAIN][GAIN_W-1:0];
    assign clamp_code = reg_q[REG_BLACK][P_CLAMP +: CLAMP_W];
    assign ofs_code   = reg_q[REG_BLACK][P_OFS +: OFS_W];
    assign ofs_use    = reg_q[REG_BLACK][P_OFS_USE];
    assign calib_run  = reg_q[REG_CTRL][0];
    assign core_run   = reg_q[REG_CTRL][1];
    assign slow_clk   = reg_q[REG_CTRL][2];
    assign strobe_inv = reg_q[REG_CTRL][3];
    assign black_inv  = reg_q[REG_CTRL][4];
    assign sleep_req  = reg_q[REG_CTRL][5];
    assign test_mode  = reg_q[REG_OUTMODE][0];
    assign msb_inv    = reg_q[REG_OUTMODE][1];
    assign all_inv    = reg_q[REG_OUTMODE][2];
    assign standby    = reg_q[REG_OUTMODE][3];
endmodule

// File: rtl/ctrl_frame_rx_chk.sv
// Checker for ctrl_frame_rx, attached by bind. Observes commit, counter, registers and flag.
module ctrl_frame_rx_chk
    import ctrl_rx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    parameter int PAY_W  = 14
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           commit,
    input logic [CNT_W-1:0]               cnt,
    input logic [WORD_W-1:0]              word,
    input logic [NUM_REGS-1:0][PAY_W-1:0] reg_q,
    input logic                           clamp_err
);
    // R1: first cycle after reset shows cleared state
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (reg_q == '0 && !clamp_err));

    // R5: registers move only after a commit pulse
    assert_hold_without_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(reg_q));

    // R4: counter never passes its saturation value
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W + 1));

    // R3: a commit closes the frame and the count restarts
    assert_commit_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt == '0));

    // R11: out-of-range clamp commit raises the flag
    assert_clamp_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && word[ADDR_W-1:0] == REG_BLACK
         && word[ADDR_W+P_CLAMP +: CLAMP_W] > CLAMP_W'(CLAMP_MAX)) |=> clamp_err);

    // R11: flag is sticky
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_err |=> clamp_err);
endmodule

bind ctrl_frame_rx ctrl_frame_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W), .PAY_W(PAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cnt(frame_cnt),
    .word(frame_word), .reg_q(reg_q), .clamp_err(clamp_err)
);

// File: tb/ctrl_frame_rx_test.sv
// Self-checking bench: table of frames walked by one loop, then directed corner tests.
module ctrl_frame_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0;
    logic [10:0] gain_code;
    logic [4:0]  clamp_code, ofs_dummy;
    logic [3:0]  ofs_code;
    logic clamp_err, ofs_use, calib_run, core_run, slow_clk, strobe_inv, black_inv;
    logic sleep_req, test_mode, msb_inv, all_inv, standby;

    int n_checks = 0, n_fail = 0;
    logic [13:0] mdl [4];
    logic        mdl_err;

    always #2 clk = ~clk;   // 250 MHz

    ctrl_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .gain_code(gain_code), .clamp_code(clamp_code), .clamp_err(clamp_err),
        .ofs_code(ofs_code), .ofs_use(ofs_use), .calib_run(calib_run), .core_run(core_run),
        .slow_clk(slow_clk), .strobe_inv(strobe_inv), .black_inv(black_inv), .sleep_req(sleep_req),
        .test_mode(test_mode), .msb_inv(msb_inv), .all_inv(all_inv), .standby(standby)
    );
    assign ofs_dummy = '0;

    // word, edge count, requirement tag
    localparam int NV = 13;
    localparam logic [15:0] VW [NV] = '{16'h0FFC, 16'h1EBC, 16'h0D61, 16'h00FE, 16'h003F,
                                        16'h0000, 16'h0000, 16'h0017, 16'h00AA, 16'h0065,
                                        16'h000D, 16'h1554, 16'hFFFF};
    localparam int VN [NV] = '{16, 16, 16, 16, 16, 15, 17, 16, 16, 16, 16, 16, 1};
    // R7 R7 R8 R9 R10 R3 R4 R10 R9 R11 R11 R2 R3
    localparam int VR [NV] = '{7, 7, 8, 9, 10, 3, 4, 10, 9, 11, 11, 2, 3};

    function automatic logic [31:0] observed();
        return {gain_code, ofs_use, ofs_code, clamp_code,
                sleep_req, black_inv, strobe_inv, slow_clk, core_run, calib_run,
                standby, all_inv, msb_inv, test_mode, clamp_err};
    endfunction

    function automatic logic [31:0] expected();
        return {mdl[0][10:0], mdl[1][9:0], mdl[2][5:0], mdl[3][3:0], mdl_err};
    endfunction

    task automatic check(input string tag);
        n_checks++;
        if (observed() !== expected()) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, observed(), expected());
        end
    endtask

    task automatic model_commit(input logic [15:0] w);
        mdl[w[1:0]] = w[15:2];
        if (w[1:0] == 2'd1 && w[6:2] > 5'd24) mdl_err = 1'b1;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = w[i % 16];
            wait_clk(6);
            ser_clk = 1'b1;
            wait_clk(6);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [15:0] w, input int n);
        ser_sel_n = 1'b0;
        wait_clk(6);
        shift_bits(w, n);
        wait_clk(6);
        ser_sel_n = 1'b1;
        wait_clk(12);
        if (n == 16) model_commit(w);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        mdl_err = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        check("R1 reset state");

        for (int v = 0; v < NV; v++) begin
            send(VW[v], VN[v]);
            check($sformatf("R%0d vector %0d", VR[v], v));
        end

        // R5: full frame with select held low does not take effect yet
        ser_sel_n = 1'b0;
        wait_clk(6);
        shift_bits(16'h0AB8, 16);
        wait_clk(30);
        check("R5 held before select rise");
        ser_sel_n = 1'b1;
        wait_clk(12);
        model_commit(16'h0AB8);
        check("R5 applied after select rise");

        // R12: clocks while deselected are ignored and do not pollute the next frame
        shift_bits(16'hFFFF, 10);
        wait_clk(6);
        check("R12 idle clocks ignored");
        send(16'h0152, 16);
        check("R12 following frame intact");

        // R3: abort after eight bits, then a valid frame
        send(16'h00FF, 8);
        check("R3 aborted frame");
        send(16'h0039, 16);
        check("R6 register 1 only");

        // R1: mid-run reset clears everything including the sticky flag
        @(negedge clk) rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        model_reset();
        wait_clk(2);
        check("R1 mid-run reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule